// File: doc/BRIEF.md
# Modulo 2^n−1 Residue Adder

This block adds two residues modulo M = 2^N − 1 and returns their sum in the same residue range. Each operand arrives already reduced to the range 0 to M − 1. The block is purely combinational, with no clock and no reset. It is meant to sit inside a residue-arithmetic datapath, for example the channel adders of a residue number system.

The block has two sections. The first is a plain binary parallel-prefix adder in three steps: per-bit generate/propagate, a carry tree and the sum XOR. A parameter chooses either a Brent-Kung tree or a Kogge-Stone tree for the carry step. The second section is a conditional excess-one unit. Two signals from the prefix section drive it: the carry out of the top bit and the group propagate of the whole word. When either is set, the unit adds one to the raw binary sum. This folds the end-around carry back in without an extra prefix level, and it maps the all-ones pattern to zero, so zero has exactly one code.

An operand equal to M (all ones) lies outside the input contract, and the result for it is not defined.

Top module: `mod_residue_adder`

## Requirements
- R1: For any operands a, b in 0..M−1, sum_out equals (a + b) mod M, where M = 2^N − 1.
- R2: sum_out never shows the all-ones pattern; zero is only ever the all-zeros code.
- R3: When a + b equals M exactly (e.g. complementary bit patterns), sum_out is 0.
- R4: When the binary sum a + b exceeds M (carry out of bit N−1 is 1), sum_out equals a + b − M, i.e. the low N bits of the binary sum plus one.
- R5: When a + b is below M, sum_out equals the plain binary sum with no increment.
- R6: Selecting the Brent-Kung tree (TOPO = 0) or the Kogge-Stone tree (TOPO = 1) gives identical sum_out for identical operands.
- R7: Boundary operands: 0 + 0 gives 0, 0 + (M−1) gives M−1, and (M−1) + (M−1) gives M−2.
- R8: sum_out settles from the operands alone, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First residue operand, 0..M−1 |
| b_in | input | N | Second residue operand, 0..M−1 |
| sum_out | output | N | Residue sum modulo 2^N − 1 |

## Verification
The operand pairs fall into four classes. Pairs that sum below M check that no spurious increment occurs. Pairs that overflow the N-bit word check the end-around carry. Complementary pairs that sum to M exactly check the group-propagate path, which is the only way to detect that case. Zero and maximum operands check the boundary codes. The bench runs a Brent-Kung instance and a Kogge-Stone instance side by side on every pair, so a fault in one tree shows up as a mismatch against the model and against the other tree. Pseudo-random pairs, including some drawn to sit at or just past M, cover bit positions that the directed cases miss.

// File: rtl/mod_residue_pkg.sv
package mod_residue_pkg;

    typedef enum int {
        TOPO_BRENT_KUNG  = 0,
        TOPO_KOGGE_STONE = 1
    } topo_e;

    // Number of combine levels a carry tree needs for a word of width w.
    function automatic int tree_levels(input int w);
        int l;
        l = 0;
        while ((1 << l) < w) l++;
        return l;
    endfunction

endpackage

// File: rtl/gp_precompute.sv
module gp_precompute #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] gen_o,
    output logic [N-1:0] prop_o
);

    always_comb begin
        gen_o  = a_in & b_in;
        prop_o = a_in ^ b_in;
    end

endmodule

// File: rtl/prefix_carry_tree.sv
module prefix_carry_tree
    import mod_residue_pkg::*;
#(
    parameter int N    = 16,
    parameter int TOPO = TOPO_BRENT_KUNG
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    output logic [N-1:0] grp_gen_o,   // carry out of span [i:0]
    output logic [N-1:0] grp_prop_o   // every bit of span [i:0] propagates
);

    localparam int LVL    = tree_levels(N);
    localparam int STAGES = (TOPO == TOPO_KOGGE_STONE) ? LVL
                          : ((LVL > 0) ? (2 * LVL - 1) : 0);

    // Lower partner of node i at stage s, or -1 when the node passes through.
    function automatic int partner(input int s, input int i);
        int k;
        int span;
        if (TOPO == TOPO_KOGGE_STONE) begin
            return (i >= (1 << s)) ? (i - (1 << s)) : -1;
        end
        if (s < LVL) begin
            span = 2 << s;
            return (((i + 1) % span) == 0) ? (i - (1 << s)) : -1;
        end
        k    = 2 * LVL - 2 - s;
        span = 2 << k;
        return ((((i + 1) % span) == (1 << k)) && ((i + 1) > span))
               ? (i - (1 << k)) : -1;
    endfunction

    logic [N-1:0] g_lvl [0:STAGES];
    logic [N-1:0] p_lvl [0:STAGES];

    assign g_lvl[0] = gen_i;
    assign p_lvl[0] = prop_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < N; i++) begin : g_node
            localparam int J = partner(s, i);
            if (J >= 0) begin : g_combine
                assign g_lvl[s+1][i] = g_lvl[s][i] | (p_lvl[s][i] & g_lvl[s][J]);
                assign p_lvl[s+1][i] = p_lvl[s][i] & p_lvl[s][J];
            end else begin : g_pass
                assign g_lvl[s+1][i] = g_lvl[s][i];
                assign p_lvl[s+1][i] = p_lvl[s][i];
            end
        end
    end

    assign grp_gen_o  = g_lvl[STAGES];
    assign grp_prop_o = p_lvl[STAGES];

endmodule

// File: rtl/excess_one_unit.sv
module excess_one_unit #(
    parameter int N = 16
) (
    input  logic [N-1:0] raw_i,
    input  logic         inc_i,
    output logic [N-1:0] res_o
);

    // ones_below[i] is set when raw bits [i-1:0] are all one.
    logic [N-1:0] ones_below;

    always_comb begin
        ones_below[0] = 1'b1;
        for (int i = 1; i < N; i++) begin
            ones_below[i] = ones_below[i-1] & raw_i[i-1];
        end
        res_o = raw_i ^ ({N{inc_i}} & ones_below);
    end

endmodule

// File: rtl/mod_residue_adder.sv
module mod_residue_adder
    import mod_residue_pkg::*;
#(
    parameter int N    = 16,
    parameter int TOPO = TOPO_BRENT_KUNG
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] sum_out
);

    logic [N-1:0] gen_bits;
    logic [N-1:0] prop_bits;
    logic [N-1:0] grp_gen;
    logic [N-1:0] grp_prop;
    logic [N-1:0] carry_in_bits;
    logic [N-1:0] raw_sum;
    logic         carry_top;
    logic         all_prop;
    logic         inc_ctl;

    gp_precompute #(.N(N)) u_gp (
        .a_in   (a_in),
        .b_in   (b_in),
        .gen_o  (gen_bits),
        .prop_o (prop_bits)
    );

    prefix_carry_tree #(.N(N), .TOPO(TOPO)) u_tree (
        .gen_i      (gen_bits),
        .prop_i     (prop_bits),
        .grp_gen_o  (grp_gen),
        .grp_prop_o (grp_prop)
    );

    always_comb begin
        carry_in_bits = {grp_gen[N-2:0], 1'b0};
        raw_sum       = prop_bits ^ carry_in_bits;
        carry_top     = grp_gen[N-1];
        all_prop      = grp_prop[N-1];
        inc_ctl       = carry_top | all_prop;
    end

    excess_one_unit #(.N(N)) u_inc (
        .raw_i (raw_sum),
        .inc_i (inc_ctl),
        .res_o (sum_out)
    );

endmodule

// File: rtl/mod_residue_adder_chk.sv
module mod_residue_adder_chk #(
    parameter int N = 16
) (
    input logic [N-1:0] a_in,
    input logic [N-1:0] b_in,
    input logic [N-1:0] sum_out,
    input logic [N-1:0] raw_sum,
    input logic         inc_ctl
);

    localparam logic [N:0] MODV = {1'b0, {N{1'b1}}};

    logic [N:0] wide_sum;
    logic       known;

    always_comb begin
        wide_sum = {1'b0, a_in} + {1'b0, b_in};
        known    = !$isunknown({a_in, b_in, sum_out, raw_sum, inc_ctl})
                   && ({1'b0, a_in} < MODV) && ({1'b0, b_in} < MODV);
        if (known) begin
            assert_no_allones_R2: assert (sum_out != {N{1'b1}})
                else $error("R2: all-ones code at output");
            assert_exact_mod_zero_R3: assert ((wide_sum != MODV) || (sum_out == '0))
                else $error("R3: a+b==M did not give zero");
            assert_plain_path_R5: assert (inc_ctl || (sum_out == raw_sum))
                else $error("R5: output differs from raw sum without increment");
            assert_inc_path_R4: assert (!inc_ctl || (sum_out == raw_sum + 1'b1))
                else $error("R4: increment path not raw+1");
            assert_mod_result_R1: assert ({1'b0, sum_out} == (wide_sum % MODV))
                else $error("R1: residue sum mismatch");
        end
    end

endmodule

bind mod_residue_adder mod_residue_adder_chk #(.N(N)) u_chk (
    .a_in    (a_in),
    .b_in    (b_in),
    .sum_out (sum_out),
    .raw_sum (raw_sum),
    .inc_ctl (inc_ctl)
);

// File: tb/mod_residue_adder_bench.sv
module mod_residue_adder_bench;

    localparam int N = 16;
    localparam longint MODV = (64'd1 << N) - 1;

    logic         clk;
    logic [N-1:0] a_drv;
    logic [N-1:0] b_drv;
    logic [N-1:0] sum_bk;
    logic [N-1:0] sum_ks;
    int           n_tests;
    int           n_fail;
    bit           finished;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    mod_residue_adder #(.N(N), .TOPO(0)) u_mod_residue_adder (
        .a_in    (a_drv),
        .b_in    (b_drv),
        .sum_out (sum_bk)
    );

    mod_residue_adder #(.N(N), .TOPO(1)) u_mod_residue_adder_ks (
        .a_in    (a_drv),
        .b_in    (b_drv),
        .sum_out (sum_ks)
    );

    function automatic longint ref_sum(input longint a, input longint b);
        return (a + b) % MODV;
    endfunction

    // Drive at the falling edge, sample 2 ns later (combinational path).
    task automatic apply_check(input longint a, input longint b, input string req);
        longint expv;
        @(negedge clk);
        a_drv = a[N-1:0];
        b_drv = b[N-1:0];
        #2;
        expv = ref_sum(a, b);
        n_tests++;
        if (longint'(sum_bk) != expv) begin
            n_fail++;
            $display("FAIL %s brent-kung a=%0d b=%0d got=%0d exp=%0d", req, a, b, sum_bk, expv);
        end
        n_tests++;
        if (longint'(sum_ks) != expv) begin
            n_fail++;
            $display("FAIL %s kogge-stone a=%0d b=%0d got=%0d exp=%0d", req, a, b, sum_ks, expv);
        end
    endtask

    task automatic t_boundary_R7;
        apply_check(0, 0, "R7");
        apply_check(0, MODV - 1, "R7");
        apply_check(MODV - 1, 0, "R7");
        apply_check(MODV - 1, MODV - 1, "R7");
    endtask

    task automatic t_exact_mod_R3;
        apply_check(16'h5555, 16'hAAAA, "R3");
        apply_check(16'h00FF, 16'hFF00, "R3");
        apply_check(1, MODV - 1, "R3");
        apply_check(16'h7FFF, 16'h8000, "R3");
        // R2: output must not be the all-ones code for these sums
        n_tests++;
        if (sum_bk == {N{1'b1}} || sum_ks == {N{1'b1}}) begin
            n_fail++;
            $display("FAIL R2 got=%0h/%0h exp!=%0h", sum_bk, sum_ks, {N{1'b1}});
        end
    endtask

    task automatic t_overflow_R4;
        apply_check(16'h8000, 16'h8000, "R4");
        apply_check(16'hFFFE, 16'h0002, "R4");
        apply_check(16'hC000, 16'h4001, "R4");
        apply_check(16'h8001, 16'h7FFF, "R4");
    endtask

    task automatic t_no_overflow_R5;
        apply_check(1, 1, "R5");
        apply_check(16'h1234, 16'h4321, "R5");
        apply_check(16'h7FFF, 16'h7FFF, "R5");
        apply_check(16'hFFFD, 1, "R5");
    endtask

    task automatic t_random_R1;
        for (int k = 0; k < 400; k++) begin
            longint a;
            longint b;
            a = longint'($urandom) % MODV;
            if (k % 4 == 0) b = MODV - a;          // sits on M
            else if (k % 4 == 1) b = (MODV - a + 1) % MODV; // one past M
            else b = longint'($urandom) % MODV;
            if (b >= MODV) b = MODV - 1;
            apply_check(a, b, "R1");
        end
    endtask

    task automatic t_topo_match_R6;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            a_drv = N'((longint'($urandom) % MODV));
            b_drv = N'((longint'($urandom) % MODV));
            #2;
            n_tests++;
            if (sum_bk != sum_ks) begin
                n_fail++;
                $display("FAIL R6 got=%0h exp=%0h", sum_bk, sum_ks);
            end
        end
    endtask

    // R8: output follows an operand change with no clock edge in between.
    task automatic t_no_clock_R8;
        @(posedge clk);
        #1;
        a_drv = 16'h0010;
        b_drv = 16'h0020;
        #1;
        n_tests++;
        if (sum_bk != 16'h0030) begin
            n_fail++;
            $display("FAIL R8 got=%0h exp=%0h", sum_bk, 16'h0030);
        end
        a_drv = 16'h0011;
        #1;
        n_tests++;
        if (sum_ks != 16'h0031) begin
            n_fail++;
            $display("FAIL R8 got=%0h exp=%0h", sum_ks, 16'h0031);
        end
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        n_tests  = 0;
        n_fail   = 0;
        finished = 1'b0;
        a_drv    = '0;
        b_drv    = '0;
        repeat (2) @(posedge clk);
        // reset state: zero operands give zero
        #2;
        n_tests++;
        if (sum_bk != '0 || sum_ks != '0) begin
            n_fail++;
            $display("FAIL R7 idle got=%0h/%0h exp=0", sum_bk, sum_ks);
        end
        t_boundary_R7();
        t_exact_mod_R3();
        t_overflow_R4();
        t_no_overflow_R5();
        t_random_R1();
        t_topo_match_R6();
        t_no_clock_R8();
        finished = 1'b1;
        report();
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog got=timeout exp=done");
            report();
        end
    end

endmodule